// File: doc/BRIEF.md
# Flash Byte Programming Sequencer

This block sits on the host side of a byte-wide flash memory and carries out the full programming algorithm for one byte per request. A client presents an address and a data byte with a valid/ready handshake. The sequencer then drives the chip-enable, output-enable and write-enable strobes, the address bus and the bidirectional data bus through a fixed series of bus cycles. It waits out the device's programming and verification delays with clock counters and reads the byte back to compare it with the intended value.

Each attempt runs in this order: a setup-command write, a write of the target address and data, a programming delay, a verify-command write, a verification delay, and a read of the target address. On a match the block pulses `done_o`. On a mismatch it runs the whole attempt again from the setup command. Once the attempt limit is used up it pulses `fail_o` instead. The delays are given in microseconds and turned into cycle counts from the clock frequency parameter. Requests may target addresses in any order.

Top module: `flash_prog_seq`

## Requirements
- R1: `req_ready_o` is high only while the sequencer is idle. A request is taken on a cycle with `req_valid_i` and `req_ready_o` both high. While a request is in progress, `req_valid_i` is ignored: no second operation starts and no bus activity follows completion.
- R2: During every write cycle, CE# and OE# behave as follows. CE# (`flash_ce_n_o`) is low while WE# (`flash_we_n_o`) is low. OE# (`flash_oe_n_o`) stays high. WE# stays low for at least `WE_LOW_CYC` consecutive clocks.
- R3: `flash_addr_o` and `flash_dq_o` hold the same value from the falling edge of WE# through the clock on which WE# returns high.
- R4: Each attempt consists of four bus cycles in this order: write of 0x40, write of the request data to the request address, write of 0xC0, and a read of the request address.
- R5: At least `PROG_CYC = ceil(CLK_HZ*PROG_US/1e6)` clocks pass between the WE# rise of the program-data write and the WE# fall of the verify-command write.
- R6: At least `VFY_CYC = ceil(CLK_HZ*VFY_US/1e6)` clocks pass between the WE# rise of the verify-command write and the OE# fall of the read.
- R7: `flash_dq_oe_o` is high only during write cycles. It is low while OE# is low and also on the clock before OE# falls.
- R8: When the read-back byte equals the request data, `done_o` is high for exactly one clock. `fail_o` stays low, and `req_ready_o` is high on that same clock.
- R9: On a mismatch the sequence restarts from the setup command. After `MAX_TRIES` attempts that all mismatch, `fail_o` pulses for one clock, no further attempt follows, and `done_o` stays low.
- R10: Successive requests to unrelated, non-monotonic addresses each complete with the address and data of their own request.
- R11: After reset, CE#, WE# and OE# are high, `flash_dq_oe_o` is low, `req_ready_o` is high, and `done_o` and `fail_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle, request accepted |
| req_addr_i | input | ADDR_W | Byte address to program |
| req_data_i | input | 8 | Byte value to program |
| done_o | output | 1 | One-clock pulse: byte verified |
| fail_o | output | 1 | One-clock pulse: attempt limit reached |
| flash_addr_o | output | ADDR_W | Flash address bus |
| flash_dq_o | output | 8 | Flash data bus, driven value |
| flash_dq_oe_o | output | 1 | Data bus drive enable |
| flash_dq_i | input | 8 | Flash data bus, sampled value |
| flash_ce_n_o | output | 1 | Chip enable, active low |
| flash_oe_n_o | output | 1 | Output enable, active low |
| flash_we_n_o | output | 1 | Write enable, active low |

## Verification
The read byte is captured on the last access clock. `done_o` or `fail_o` then follows two clock edges later, and `req_ready_o` rises on the same edge as the pulse. The bench samples every output on the falling clock edge and checks each pulse and the one after it on consecutive falling edges. The delay requirements are lower bounds between strobe edges. The bench therefore stamps every WE# and OE# transition with a cycle count and compares the gaps against cycle counts it derives itself from the clock and microsecond parameters. Read-back mismatches come from a bench flash model that corrupts a chosen number of reads, so the expected number of attempts is known before each request.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam logic [7:0] CMD_PGM_SETUP  = 8'h40;
  localparam logic [7:0] CMD_PGM_VERIFY = 8'hC0;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_SETUP, SQ_PROG, SQ_PWAIT, SQ_VFY, SQ_VWAIT, SQ_READ, SQ_CHECK
  } sq_state_e;

  typedef enum logic [2:0] {
    BC_IDLE, BC_SET, BC_PULSE, BC_HOLD, BC_TURN, BC_ACC
  } bc_state_e;
endpackage

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WE_LOW_CYC = 3,
  parameter int RD_CYC     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              done_o,
  output logic [7:0]        rd_data_o,
  output logic              ce_n_o,
  output logic              we_n_o,
  output logic              oe_n_o,
  output logic              dq_oe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        dq_o,
  input  logic [7:0]        dq_i
);
  localparam int MAX_C = (WE_LOW_CYC > RD_CYC) ? WE_LOW_CYC : RD_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  bc_state_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [7:0]        rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= BC_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      rd_q   <= '0;
    end else begin
      unique case (st_q)
        BC_IDLE: if (start_i) begin
          addr_q <= addr_i;
          data_q <= data_i;
          st_q   <= write_i ? BC_SET : BC_TURN;
        end
        BC_SET: begin
          st_q  <= BC_PULSE;
          cnt_q <= CNT_W'(WE_LOW_CYC - 1);
        end
        BC_PULSE: begin
          if (cnt_q == '0) st_q <= BC_HOLD;
          else             cnt_q <= cnt_q - 1'b1;
        end
        BC_HOLD: st_q <= BC_IDLE;
        BC_TURN: begin
          st_q  <= BC_ACC;
          cnt_q <= CNT_W'(RD_CYC - 1);
        end
        BC_ACC: begin
          if (cnt_q == '0) begin
            rd_q <= dq_i;
            st_q <= BC_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= BC_IDLE;
      endcase
    end
  end

  // strobes decoded from one state register, no overlapping terms
  always_comb begin
    ce_n_o  = 1'b1;
    we_n_o  = 1'b1;
    oe_n_o  = 1'b1;
    dq_oe_o = 1'b0;
    unique case (st_q)
      BC_SET, BC_HOLD: begin ce_n_o = 1'b0; dq_oe_o = 1'b1; end
      BC_PULSE:        begin ce_n_o = 1'b0; dq_oe_o = 1'b1; we_n_o = 1'b0; end
      BC_TURN:         ce_n_o = 1'b0;
      BC_ACC:          begin ce_n_o = 1'b0; oe_n_o = 1'b0; end
      default: ;
    endcase
  end

  assign done_o    = (st_q == BC_HOLD) || ((st_q == BC_ACC) && (cnt_q == '0));
  assign rd_data_o = rd_q;
  assign addr_o    = addr_q;
  assign dq_o      = data_q;
endmodule

// File: rtl/flash_wait_timer.sv
module flash_wait_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             exp_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= len_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign exp_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CLK_HZ     = 200_000_000,
  parameter int PROG_US    = 10,
  parameter int VFY_US     = 6,
  parameter int WE_LOW_CYC = 3,
  parameter int RD_CYC     = 3,
  parameter int MAX_TRIES  = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        req_data_i,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic [7:0]        flash_dq_o,
  output logic              flash_dq_oe_o,
  input  logic [7:0]        flash_dq_i,
  output logic              flash_ce_n_o,
  output logic              flash_oe_n_o,
  output logic              flash_we_n_o
);
  localparam int CLK_KHZ  = CLK_HZ / 1000;
  localparam int PROG_CYC = (CLK_KHZ * PROG_US + 999) / 1000;
  localparam int VFY_CYC  = (CLK_KHZ * VFY_US + 999) / 1000;
  localparam int MAX_WAIT = (PROG_CYC > VFY_CYC) ? PROG_CYC : VFY_CYC;
  localparam int TMR_W    = $clog2(MAX_WAIT + 1);
  localparam int TRY_W    = $clog2(MAX_TRIES + 1);

  sq_state_e         st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [TRY_W-1:0]  tries_q;
  logic              issue_q, tmr_go_q, done_q, fail_q;
  logic              bc_done, tmr_exp;
  logic [7:0]        bc_rd, bc_wdata;
  logic [TMR_W-1:0]  tmr_len;

  always_comb begin
    unique case (st_q)
      SQ_SETUP: bc_wdata = CMD_PGM_SETUP;
      SQ_VFY:   bc_wdata = CMD_PGM_VERIFY;
      default:  bc_wdata = data_q;
    endcase
  end

  assign tmr_len = (st_q == SQ_VWAIT) ? TMR_W'(VFY_CYC) : TMR_W'(PROG_CYC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= SQ_IDLE;
      addr_q   <= '0;
      data_q   <= '0;
      tries_q  <= '0;
      issue_q  <= 1'b0;
      tmr_go_q <= 1'b0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      issue_q  <= 1'b0;
      tmr_go_q <= 1'b0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
      unique case (st_q)
        SQ_IDLE: if (req_valid_i) begin
          addr_q  <= req_addr_i;
          data_q  <= req_data_i;
          tries_q <= TRY_W'(1);
          issue_q <= 1'b1;
          st_q    <= SQ_SETUP;
        end
        SQ_SETUP: if (bc_done) begin st_q <= SQ_PROG;  issue_q  <= 1'b1; end
        SQ_PROG:  if (bc_done) begin st_q <= SQ_PWAIT; tmr_go_q <= 1'b1; end
        SQ_PWAIT: if (tmr_exp) begin st_q <= SQ_VFY;   issue_q  <= 1'b1; end
        SQ_VFY:   if (bc_done) begin st_q <= SQ_VWAIT; tmr_go_q <= 1'b1; end
        SQ_VWAIT: if (tmr_exp) begin st_q <= SQ_READ;  issue_q  <= 1'b1; end
        SQ_READ:  if (bc_done) st_q <= SQ_CHECK;
        SQ_CHECK: begin
          if (bc_rd == data_q) begin
            done_q <= 1'b1;
            st_q   <= SQ_IDLE;
          end else if (tries_q == TRY_W'(MAX_TRIES)) begin
            fail_q <= 1'b1;
            st_q   <= SQ_IDLE;
          end else begin
            tries_q <= tries_q + 1'b1;
            issue_q <= 1'b1;
            st_q    <= SQ_SETUP;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  flash_bus_cycle #(
    .ADDR_W(ADDR_W), .WE_LOW_CYC(WE_LOW_CYC), .RD_CYC(RD_CYC)
  ) u_bus (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (issue_q),
    .write_i  (st_q != SQ_READ),
    .addr_i   (addr_q),
    .data_i   (bc_wdata),
    .done_o   (bc_done),
    .rd_data_o(bc_rd),
    .ce_n_o   (flash_ce_n_o),
    .we_n_o   (flash_we_n_o),
    .oe_n_o   (flash_oe_n_o),
    .dq_oe_o  (flash_dq_oe_o),
    .addr_o   (flash_addr_o),
    .dq_o     (flash_dq_o),
    .dq_i     (flash_dq_i)
  );

  flash_wait_timer #(.CNT_W(TMR_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tmr_go_q),
    .len_i  (tmr_len),
    .exp_o  (tmr_exp)
  );

  assign req_ready_o = (st_q == SQ_IDLE);
  assign done_o      = done_q;
  assign fail_o      = fail_q;
endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk #(
  parameter int ADDR_W     = 16,
  parameter int WE_LOW_CYC = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              done_o,
  input logic              fail_o,
  input logic [ADDR_W-1:0] flash_addr_o,
  input logic [7:0]        flash_dq_o,
  input logic              flash_dq_oe_o,
  input logic              flash_ce_n_o,
  input logic              flash_oe_n_o,
  input logic              flash_we_n_o
);
  logic [7:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  low_cnt_q <= '0;
    else if (!flash_we_n_o && low_cnt_q != 8'hFF) low_cnt_q <= low_cnt_q + 1'b1;
    else if (flash_we_n_o)                        low_cnt_q <= '0;
  end

  assert_ready_bus_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> flash_ce_n_o);

  assert_we_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_we_n_o |-> (!flash_ce_n_o && flash_oe_n_o));

  assert_we_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flash_we_n_o) |-> (low_cnt_q >= 8'(WE_LOW_CYC)));

  assert_hold_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_we_n_o |=> ($stable(flash_addr_o) && $stable(flash_dq_o)));

  assert_bus_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_oe_n_o |-> (!flash_dq_oe_o && !$past(flash_dq_oe_o)));

  assert_drive_in_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_dq_oe_o |-> !flash_ce_n_o);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_result_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, fail_o}));
endmodule

bind flash_prog_seq flash_prog_seq_chk #(
  .ADDR_W(ADDR_W), .WE_LOW_CYC(WE_LOW_CYC)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .done_o       (done_o),
  .fail_o       (fail_o),
  .flash_addr_o (flash_addr_o),
  .flash_dq_o   (flash_dq_o),
  .flash_dq_oe_o(flash_dq_oe_o),
  .flash_ce_n_o (flash_ce_n_o),
  .flash_oe_n_o (flash_oe_n_o),
  .flash_we_n_o (flash_we_n_o)
);

// File: tb/flash_prog_seq_bench.sv
`timescale 1ns/1ps
module flash_prog_seq_bench;
  localparam int AW     = 16;
  localparam int CLKHZ  = 20_000_000;  // small value keeps delay counts short
  localparam int P_US   = 10;
  localparam int V_US   = 6;
  localparam int WEL    = 3;
  localparam int RDC    = 3;
  localparam int TRIES  = 25;
  localparam int EXP_PROG = (CLKHZ / 1000 * P_US + 999) / 1000;
  localparam int EXP_VFY  = (CLKHZ / 1000 * V_US + 999) / 1000;
  localparam int NEV    = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic ready, done, fail, dq_oe, ce_n, oe_n, we_n;
  logic [AW-1:0] f_addr;
  logic [7:0] f_dq, f_dq_in;

  always #2.5 clk = ~clk;

  flash_prog_seq #(
    .ADDR_W(AW), .CLK_HZ(CLKHZ), .PROG_US(P_US), .VFY_US(V_US),
    .WE_LOW_CYC(WEL), .RD_CYC(RDC), .MAX_TRIES(TRIES)
  ) u_flash_prog_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(ready),
    .req_addr_i(req_addr), .req_data_i(req_data),
    .done_o(done), .fail_o(fail),
    .flash_addr_o(f_addr), .flash_dq_o(f_dq), .flash_dq_oe_o(dq_oe),
    .flash_dq_i(f_dq_in),
    .flash_ce_n_o(ce_n), .flash_oe_n_o(oe_n), .flash_we_n_o(we_n)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // flash model: corrupts the first bad_reads read-backs
  logic [7:0] tgt = '0;
  int bad_reads = 0, rd_count = 0;
  assign f_dq_in = (rd_count <= bad_reads) ? (tgt ^ 8'h5A) : tgt;

  // bus event log
  int ev_n = 0;
  bit ev_wr[NEV];
  logic [AW-1:0] ev_addr[NEV];
  logic [7:0] ev_data[NEV];
  int ev_t0[NEV], ev_t1[NEV], ev_low[NEV];
  bit ev_stable[NEV];
  int release_viol = 0;
  logic p_we = 1'b1, p_oe = 1'b1, p_dqoe = 1'b0;
  int fall_t = 0, low_n = 0;
  logic [AW-1:0] fall_a = '0;
  logic [7:0] fall_d = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_we && !we_n) begin fall_t = cyc; fall_a = f_addr; fall_d = f_dq; low_n = 0; end
      if (!we_n) low_n++;
      if (!p_we && we_n && ev_n < NEV) begin
        ev_wr[ev_n] = 1'b1; ev_addr[ev_n] = f_addr; ev_data[ev_n] = f_dq;
        ev_t0[ev_n] = fall_t; ev_t1[ev_n] = cyc; ev_low[ev_n] = low_n;
        ev_stable[ev_n] = (f_addr == fall_a) && (f_dq == fall_d) && !ce_n;
        ev_n++;
      end
      if (p_oe && !oe_n) begin
        rd_count++;
        if (p_dqoe) release_viol++;
        if (ev_n < NEV) begin
          ev_wr[ev_n] = 1'b0; ev_addr[ev_n] = f_addr; ev_data[ev_n] = '0;
          ev_t0[ev_n] = cyc; ev_t1[ev_n] = cyc; ev_low[ev_n] = 0; ev_stable[ev_n] = 1'b1;
          ev_n++;
        end
      end
      if (!oe_n && dq_oe) release_viol++;
      if (dq_oe && !(!ce_n && oe_n)) release_viol++;
      p_we = we_n; p_oe = oe_n; p_dqoe = dq_oe;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // runs one request; result 1 = done, 2 = fail, 0 = timeout
  task automatic run_req(input logic [AW-1:0] a, input logic [7:0] d, input int bad,
                         input bit noise, output int result);
    int busy_ready = 0;
    ev_n = 0; rd_count = 0; bad_reads = bad; tgt = d; result = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d;
    while (!ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 30000; i++) begin
      if (noise && i >= 5 && i < 40) begin
        req_valid = 1'b1; req_addr = a ^ 16'h0F0F; req_data = ~d;
      end else if (noise) req_valid = 1'b0;
      if (done || fail) begin result = done ? 1 : 2; break; end
      if (ready) busy_ready++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(busy_ready == 0, "R1 ready low while busy", busy_ready, 0);
    chk(ready == 1'b1, "R8 ready with result pulse", ready, 1);
    @(negedge clk);
    chk(!done && !fail, "R8 result pulse one clock", done | fail, 0);
  endtask

  task automatic check_log(input logic [AW-1:0] a, input logic [7:0] d, input int tries,
                           input string tag);
    int seq_err = 0, w_err = 0, s_err = 0, g1_err = 0, g2_err = 0;
    chk(ev_n == 4 * tries, {tag, " attempt count"}, ev_n, 4 * tries);
    for (int k = 0; k < tries && 4 * k + 3 < ev_n; k++) begin
      int b = 4 * k;
      if (!(ev_wr[b] && ev_data[b] == 8'h40)) seq_err++;
      if (!(ev_wr[b+1] && ev_data[b+1] == d && ev_addr[b+1] == a)) seq_err++;
      if (!(ev_wr[b+2] && ev_data[b+2] == 8'hC0)) seq_err++;
      if (!(!ev_wr[b+3] && ev_addr[b+3] == a)) seq_err++;
      for (int j = 0; j < 3; j++) begin
        if (ev_low[b+j] < WEL) w_err++;
        if (!ev_stable[b+j]) s_err++;
      end
      if (ev_t0[b+2] - ev_t1[b+1] < EXP_PROG) g1_err++;
      if (ev_t0[b+3] - ev_t1[b+2] < EXP_VFY) g2_err++;
    end
    chk(seq_err == 0, {tag, " R4 command order"}, seq_err, 0);
    chk(w_err == 0, {tag, " R2 WE low width"}, w_err, 0);
    chk(s_err == 0, {tag, " R3 addr/data stable"}, s_err, 0);
    chk(g1_err == 0, {tag, " R5 program wait"}, g1_err, 0);
    chk(g2_err == 0, {tag, " R6 verify wait"}, g2_err, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ce_n && we_n && oe_n, "R11 strobes high", {ce_n, we_n, oe_n}, 7);
    chk(!dq_oe, "R11 bus released", dq_oe, 0);
    chk(ready && !done && !fail, "R11 ready/done/fail", {ready, done, fail}, 4);
  endtask

  task automatic t_single();
    int r;
    run_req(16'h1234, 8'hA5, 0, 1'b0, r);
    chk(r == 1, "R8 done on match", r, 1);
    check_log(16'h1234, 8'hA5, 1, "single");
  endtask

  task automatic t_retry();
    int r;
    run_req(16'h0042, 8'h3C, 2, 1'b0, r);
    chk(r == 1, "R9 done after retries", r, 1);
    check_log(16'h0042, 8'h3C, 3, "R9 retry");
  endtask

  task automatic t_fail();
    int r;
    run_req(16'h7777, 8'h81, 1000, 1'b0, r);
    chk(r == 2, "R9 fail after limit", r, 2);
    check_log(16'h7777, 8'h81, TRIES, "R9 limit");
  endtask

  task automatic t_any_order();
    logic [AW-1:0] al[4] = '{16'hFFFF, 16'h0001, 16'h8000, 16'h00FE};
    logic [7:0] dl[4] = '{8'h00, 8'hFF, 8'h69, 8'h96};
    for (int i = 0; i < 4; i++) begin
      int r;
      run_req(al[i], dl[i], 0, 1'b0, r);
      chk(r == 1, "R10 done per address", r, 1);
      check_log(al[i], dl[i], 1, "R10 order");
    end
  endtask

  task automatic t_busy_ignore();
    int r, act = 0;
    run_req(16'h2468, 8'h5E, 0, 1'b1, r);
    chk(r == 1, "R1 done with valid noise", r, 1);
    check_log(16'h2468, 8'h5E, 1, "R1 noise");
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!ce_n) act++;
    end
    chk(act == 0, "R1 no extra operation", act, 0);
  endtask

  bit finished = 1'b0;
  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_retry();
    t_any_order();
    t_busy_ignore();
    t_fail();
    chk(release_viol == 0, "R7 data bus drive", release_viol, 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule